// File: doc/BRIEF.md
# NAND Flash Controller Event and Interrupt Status Unit

This unit gathers the events of a NAND flash controller into one status word and raises a single interrupt line. The events are command completion, transfer completion and edges of the flash ready/busy pin. Command completion and transfer completion arrive as one-cycle pulses. The ready/busy pin is asynchronous, so it is synchronised and then edge-detected. A configuration bit chooses which ready/busy edge also raises a dedicated edge event. Event bits stay set until software reads the status word. The status word also shows two live levels: whether the controller is enabled, and whether an operation is in progress.

Software chooses which status bits may interrupt. It writes ones to an enable register to set bits in an interrupt mask, and writes ones to a disable register to clear them. The mask can be read back at its own address. The interrupt output is high while any status bit that is also set in the mask is high.

Registers are reached through a word-addressed port. The word addresses are: 0 configuration, 1 control, 2 status, 3 interrupt enable, 4 interrupt disable, 5 mask.

Top module: `flash_evt_irq`

## Requirements
- R1: After reset, with the ready/busy pin high, the status word, the mask, the configuration register and `irq` are all zero.
- R2: Writing control (address 1) with bit 0 set and bit 1 clear sets status bit 0. Writing it with bit 1 set and bit 0 clear clears status bit 0.
- R3: A control write with both bit 0 and bit 1 set leaves status bit 0 unchanged.
- R4: A `cmd_done` pulse sets status bit 17, and an `xfr_done` pulse sets status bit 16. Each bit stays set until a status read.
- R5: The ready/busy pin passes through two synchroniser flops. A rising edge sets status bit 4 and a falling edge sets status bit 5. The bit is visible after the third clock edge that follows the pin change.
- R6: Configuration bit 12 selects which synchronised edge sets status bit 24: 0 selects rising, 1 selects falling. The other edge leaves bit 24 clear.
- R7: Reading status (address 2) clears bits 4, 5, 16, 17 and 24. An event that arrives in the same cycle as the read is kept. Bits 0 and 8 are not affected by the read.
- R8: Ones written to address 3 set the matching mask bits, and ones written to address 4 clear them. The mask reads at address 5, and a write to address 5 has no effect.
- R9: `irq` is high exactly when the bitwise AND of the status word and the mask is nonzero.
- R10: Status bit 8 follows the `busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; has the clear side effect at the status address |
| addr | input | AW | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register, combinational |
| cmd_done | input | 1 | One-cycle command completion pulse |
| xfr_done | input | 1 | One-cycle transfer completion pulse |
| busy | input | 1 | High while an operation is in progress |
| rb_pin | input | 1 | Asynchronous ready/busy pin from the flash |
| irq | output | 1 | Interrupt request |

## Verification
A vector table covers these cases:
- each completion event alone, with its own mask bit set and then with only the other event's mask bit set;
- both events at once;
- a full mask with no events.

Together these separate an OR of status and mask from the required AND, and show whether each mask bit is tied to the correct status bit.

Directed tests then cover the remaining behaviour:
- the ready/busy pin is toggled under both polarity settings, which tells the raw edge bits apart from the selected-edge event;
- the status is read in the same cycle as a command-done pulse, which shows whether a late event survives the clear;
- double writes to the control register;
- writes to the read-only mask address.

// File: rtl/flash_evt_irq.sv
module flash_evt_irq #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          cmd_done,
  input  logic          xfr_done,
  input  logic          busy,
  input  logic          rb_pin,
  output logic          irq
);
  localparam logic [AW-1:0] A_CFG  = AW'(0);
  localparam logic [AW-1:0] A_CTRL = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);
  localparam logic [AW-1:0] A_IEN  = AW'(3);
  localparam logic [AW-1:0] A_IDIS = AW'(4);
  localparam logic [AW-1:0] A_MASK = AW'(5);

  localparam int B_EN = 0, B_RISE = 4, B_FALL = 5, B_BUSY = 8;
  localparam int B_XFR = 16, B_CMD = 17, B_EDGE = 24, B_POL = 12;

  localparam logic [31:0] EVT_BITS  = (32'd1 << B_RISE) | (32'd1 << B_FALL) |
                                      (32'd1 << B_XFR) | (32'd1 << B_CMD) |
                                      (32'd1 << B_EDGE);
  localparam logic [31:0] IMPL_BITS = EVT_BITS | (32'd1 << B_EN) | (32'd1 << B_BUSY);

  logic [2:0]  rb_q;
  logic [31:0] cfg_q, evt_q, mask_q, evt_set, status;
  logic        en_q;

  wire rise   = rb_q[1] & ~rb_q[2];
  wire fall   = ~rb_q[1] & rb_q[2];
  wire sel_ev = cfg_q[B_POL] ? fall : rise;
  wire st_rd  = rd_en && addr == A_STAT;
  wire ien_wr = wr_en && addr == A_IEN;
  wire idi_wr = wr_en && addr == A_IDIS;

  always_comb begin
    evt_set = '0;
    evt_set[B_RISE] = rise;
    evt_set[B_FALL] = fall;
    evt_set[B_XFR]  = xfr_done;
    evt_set[B_CMD]  = cmd_done;
    evt_set[B_EDGE] = sel_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_q   <= 3'b111;
      cfg_q  <= '0;
      evt_q  <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      rb_q  <= {rb_q[1:0], rb_pin};
      evt_q <= (st_rd ? 32'd0 : evt_q) | evt_set;
      if (wr_en && addr == A_CFG) cfg_q <= wdata;
      if (wr_en && addr == A_CTRL) begin
        if (wdata[1:0] == 2'b01) en_q <= 1'b1;
        else if (wdata[1:0] == 2'b10) en_q <= 1'b0;
      end
      mask_q <= (mask_q | (ien_wr ? (wdata & IMPL_BITS) : 32'd0))
                & ~(idi_wr ? wdata : 32'd0);
    end
  end

  always_comb begin
    status = evt_q & EVT_BITS;
    status[B_EN]   = en_q;
    status[B_BUSY] = busy;
  end

  assign irq = |(status & mask_q);

  always_comb begin
    case (addr)
      A_CFG:   rdata = cfg_q;
      A_STAT:  rdata = status;
      A_MASK:  rdata = mask_q;
      default: rdata = '0;
    endcase
  end
endmodule

module flash_evt_irq_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          cmd_done,
  input logic [31:0]   status,
  input logic [31:0]   mask,
  input logic          irq
);
  localparam logic [31:0] IMPL = 32'h0103_0131;

  // R4
  cmd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> status[17]);
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(2) && !cmd_done) |=> !status[17]);
  // R3
  ctrl_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1) && wdata[1:0] == 2'b11) |=> $stable(status[0]));
  // R8
  ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3)) |=> ((mask & $past(wdata) & IMPL) == ($past(wdata) & IMPL)));
  // R8
  idis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4)) |=> ((mask & $past(wdata)) == 32'd0));
  // R9
  no_mask_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 32'd0) |-> !irq);
endmodule

bind flash_evt_irq flash_evt_irq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .cmd_done(cmd_done), .status(status), .mask(mask_q), .irq(irq)
);

// File: tb/flash_evt_irq_tb_top.sv
module flash_evt_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cmd_done = 1'b0, xfr_done = 1'b0, busy = 1'b0, rb_pin = 1'b1;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] d;

  always #10 clk = ~clk;

  flash_evt_irq #(.AW(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cmd_done(cmd_done), .xfr_done(xfr_done),
    .busy(busy), .rb_pin(rb_pin), .irq(irq)
  );

  // {cmd, xfr, mask_cmd, mask_xfr, exp_irq}
  localparam logic [4:0] TBL [8] = '{
    5'b10101, 5'b10010, 5'b01011, 5'b01100,
    5'b11000, 5'b11111, 5'b00110, 5'b10111
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'd5, d); check("R1 mask", d, 32'd0);
    rd(3'd0, d); check("R1 cfg", d, 32'd0);
    rd(3'd2, d); check("R1 status", d, 32'd0);

    // R2 / R3
    wr(3'd1, 32'd1); rd(3'd2, d); check("R2 enable", d & 32'h1, 32'h1);
    wr(3'd1, 32'd3); rd(3'd2, d); check("R3 both keeps 1", d & 32'h1, 32'h1);
    wr(3'd1, 32'd2); rd(3'd2, d); check("R2 disable", d & 32'h1, 32'h0);
    wr(3'd1, 32'd3); rd(3'd2, d); check("R3 both keeps 0", d & 32'h1, 32'h0);

    // R4 / R9 table
    foreach (TBL[i]) begin
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd2, d);
      @(negedge clk); cmd_done = TBL[i][4]; xfr_done = TBL[i][3];
      @(negedge clk); cmd_done = 1'b0; xfr_done = 1'b0;
      wr(3'd3, {14'd0, TBL[i][2], TBL[i][1], 16'd0});
      #1 check($sformatf("R9 irq vec %0d", i), {31'd0, irq}, {31'd0, TBL[i][0]});
      rd(3'd2, d);
      check($sformatf("R4 events vec %0d", i), d & 32'h0003_0000,
            {14'd0, TBL[i][4], TBL[i][3], 16'd0});
    end

    // R7 clear and level bit
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd1, 32'd1);
    @(negedge clk); cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
    rd(3'd2, d); check("R7 first read", d, 32'h0002_0001);
    rd(3'd2, d); check("R7 cleared, level kept", d, 32'h0000_0001);
    // R7 same-cycle event kept
    @(negedge clk); addr = 3'd2; rd_en = 1'b1; cmd_done = 1'b1;
    @(negedge clk); rd_en = 1'b0; cmd_done = 1'b0;
    rd(3'd2, d); check("R7 same-cycle event", d & 32'h0002_0000, 32'h0002_0000);
    wr(3'd1, 32'd2);

    // R10
    busy = 1'b1; rd(3'd2, d); check("R10 busy high", d & 32'h100, 32'h100);
    busy = 1'b0; rd(3'd2, d); check("R10 busy low", d & 32'h100, 32'h0);

    // R5 / R6 rising polarity
    rd(3'd2, d);
    @(negedge clk); rb_pin = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd2, d); check("R5 fall, R6 no edge evt", d & 32'h0100_0030, 32'h20);
    @(negedge clk); rb_pin = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd2, d); check("R5 rise, R6 edge evt", d & 32'h0100_0030, 32'h0100_0010);

    // R6 falling polarity with irq
    wr(3'd0, 32'h0000_1000);
    rd(3'd0, d); check("R6 cfg readback", d, 32'h0000_1000);
    wr(3'd3, 32'h0100_0000);
    @(negedge clk); rb_pin = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 irq on selected edge", {31'd0, irq}, 32'd1);
    rd(3'd2, d); check("R6 fall evt", d & 32'h0100_0030, 32'h0100_0020);
    check("R9 irq after clear", {31'd0, irq}, 32'd0);
    @(negedge clk); rb_pin = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 rise ignored for irq", {31'd0, irq}, 32'd0);
    rd(3'd2, d); check("R6 rise only raw bit", d & 32'h0100_0030, 32'h10);

    // R8
    rd(3'd5, d); check("R8 mask readback", d, 32'h0100_0000);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); check("R8 mask read-only", d, 32'h0100_0000);
    wr(3'd3, 32'h0003_0000);
    wr(3'd4, 32'h0100_0000);
    rd(3'd5, d); check("R8 set and clear", d, 32'h0003_0000);

    summary();
  end
endmodule